// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog for a processor subsystem. It counts single-cycle tick strobes that come from a slow, free-running oscillator that is independent of the system clock. Software must restart it before the count reaches the selected timeout. If it does not, the block drives a reset pulse of fixed length into the system.

A small control register holds three fields: an enable bit, a self-clearing restart bit and a 3-bit period select. The period select picks one of eight timeouts. Each code doubles the timeout of the code below it. Power-on reset clears the register, so the watchdog starts disabled. An active power-down indicator stops and clears the count. All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `sentry_wdt`

## Requirements
- R1: With period select code n (0..7, binary on `ctl_sel`), the timeout is BASE_TICKS << n ticks. Code 0 gives BASE_TICKS ticks. `wdt_rst` goes high in the cycle after the clock edge that samples the tick completing that many ticks since the count was last cleared. One tick fewer leaves `wdt_rst` low.
- R2: Code 7 gives the longest timeout, 128 times the code-0 timeout.
- R3: Power-on reset (`por_n` low) clears the enable bit, the period select, the restart bit, the count and `wdt_rst`. While the enable bit is 0, ticks are ignored and the count is held at zero.
- R4: While `pdown` is high, ticks are ignored and the count is held at zero. The enable bit keeps its value. Counting starts again from zero when `pdown` falls.
- R5: A control write with `ctl_restart_in`=1 clears the count. The restart takes priority over a tick that arrives in the same cycle.
- R6: Only cycles with `tick` high advance the count. System clock cycles without a tick never cause a timeout.
- R7: The restart bit reads back as 1 for one cycle after a write that sets it. It then reads 0 unless it is written again.
- R8: `wdt_rst` stays high for exactly PULSE_LEN system clocks. Ticks during the pulse are ignored, and counting resumes from zero once the pulse ends.
- R9: Changing the period select while counting does not clear the count. The new timeout applies at the next tick. If the count already equals or exceeds the new timeout, that next tick fires.
- R10: A control write (`ctl_wr`=1) loads the enable bit and the period select together. Both read back on `ctl_en` and `ctl_sel` from the next cycle. Without a write, they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pdown | input | 1 | Power-down indicator, active high |
| tick | input | 1 | One-cycle strobe from the independent oscillator |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en_in | input | 1 | Enable value to write |
| ctl_restart_in | input | 1 | Restart request to write |
| ctl_sel_in | input | 3 | Period select to write |
| ctl_en | output | 1 | Enable bit readback |
| ctl_restart | output | 1 | Restart bit readback (self-clearing) |
| ctl_sel | output | 3 | Period select readback |
| wdt_rst | output | 1 | Reset pulse output |

## Verification
The hardest situation to reach is a period-select change in the middle of a count. The count is internal, so the only way to place it at a known value is to restart the watchdog, then apply an exact number of tick strobes, then write a new select without the restart bit. The stimulus covers both directions from there. When the select shrinks below the count already reached, the very next tick must fire. When the select grows, the boundary must land exactly one tick after the new limit minus one.

// File: rtl/sentry_pkg.sv
package sentry_pkg;
  localparam int SEL_W     = 3;
  localparam int NUM_CODES = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             restart;
    logic [SEL_W-1:0] sel;
  } sentry_ctl_t;
endpackage

// File: rtl/sentry_ctrl.sv
module sentry_ctrl
  import sentry_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr,
  input  logic             en_in,
  input  logic             restart_in,
  input  logic [SEL_W-1:0] sel_in,
  output sentry_ctl_t      ctl
);
  sentry_ctl_t ctl_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl_q <= '0;
    end else begin
      // restart lives for one cycle unless written again
      ctl_q.restart <= wr & restart_in;
      if (wr) begin
        ctl_q.en  <= en_in;
        ctl_q.sel <= sel_in;
      end
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/sentry_counter.sv
module sentry_counter
  import sentry_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int CNT_W      = $clog2(BASE_TICKS << (NUM_CODES - 1)) + 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             active,
  input  logic             restart,
  input  logic             hold,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);
  logic [CNT_W-1:0] lim_tbl [NUM_CODES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   next_cnt;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    assign lim_tbl[g] = CNT_W'(BASE_TICKS) << g;
  end

  assign limit    = lim_tbl[sel];
  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign fire     = active && !restart && !hold && tick &&
                    (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (!active || restart || hold) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= fire ? '0 : next_cnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sentry_pulse.sv
module sentry_pulse #(
  parameter int PULSE_LEN = 4,
  parameter int PW_W      = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic busy
);
  logic [PW_W-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= PW_W'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/sentry_wdt.sv
module sentry_wdt
  import sentry_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int PULSE_LEN  = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pdown,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic             ctl_en_in,
  input  logic             ctl_restart_in,
  input  logic [SEL_W-1:0] ctl_sel_in,
  output logic             ctl_en,
  output logic             ctl_restart,
  output logic [SEL_W-1:0] ctl_sel,
  output logic             wdt_rst
);
  sentry_ctl_t ctl;
  logic        active;
  logic        fire;
  logic        busy;

  sentry_ctrl u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .wr        (ctl_wr),
    .en_in     (ctl_en_in),
    .restart_in(ctl_restart_in),
    .sel_in    (ctl_sel_in),
    .ctl       (ctl)
  );

  assign active = ctl.en && !pdown;

  sentry_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk    (clk),
    .por_n  (por_n),
    .active (active),
    .restart(ctl.restart),
    .hold   (busy),
    .tick   (tick),
    .sel    (ctl.sel),
    .fire   (fire)
  );

  sentry_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk  (clk),
    .por_n(por_n),
    .fire (fire),
    .busy (busy)
  );

  assign ctl_en      = ctl.en;
  assign ctl_restart = ctl.restart;
  assign ctl_sel     = ctl.sel;
  assign wdt_rst     = busy;
endmodule

// File: rtl/sentry_wdt_chk.sv
module sentry_wdt_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       por_n,
  input logic       pdown,
  input logic       tick,
  input logic       ctl_wr,
  input logic       ctl_en,
  input logic       ctl_restart,
  input logic [2:0] ctl_sel,
  input logic       wdt_rst
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       run_q <= '0;
    else if (wdt_rst) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    !ctl_wr |=> !ctl_restart); // R7

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !ctl_wr |=> ($stable(ctl_sel) && $stable(ctl_en))); // R10

  AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_rst) |-> $past(tick && ctl_en)); // R6

  AST_PDOWN_NO_FIRE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_rst) |-> !$past(pdown)); // R4

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    run_q <= RW'(PULSE_LEN)); // R8

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdt_rst) |-> run_q == RW'(PULSE_LEN)); // R8
endmodule

bind sentry_wdt sentry_wdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .pdown      (pdown),
  .tick       (tick),
  .ctl_wr     (ctl_wr),
  .ctl_en     (ctl_en),
  .ctl_restart(ctl_restart),
  .ctl_sel    (ctl_sel),
  .wdt_rst    (wdt_rst)
);

// File: tb/sentry_wdt_bench.sv
`timescale 1ns/1ps
module sentry_wdt_bench;
  localparam int BASE = 16;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       pdown = 1'b0;
  logic       tick = 1'b0;
  logic       ctl_wr = 1'b0;
  logic       ctl_en_in = 1'b0;
  logic       ctl_restart_in = 1'b0;
  logic [2:0] ctl_sel_in = 3'd0;
  logic       ctl_en;
  logic       ctl_restart;
  logic [2:0] ctl_sel;
  logic       wdt_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sentry_wdt #(.BASE_TICKS(BASE), .PULSE_LEN(PLEN)) u_sentry_wdt (
    .clk(clk), .por_n(por_n), .pdown(pdown), .tick(tick),
    .ctl_wr(ctl_wr), .ctl_en_in(ctl_en_in), .ctl_restart_in(ctl_restart_in),
    .ctl_sel_in(ctl_sel_in), .ctl_en(ctl_en), .ctl_restart(ctl_restart),
    .ctl_sel(ctl_sel), .wdt_rst(wdt_rst)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(bit en, bit rs, logic [2:0] sel);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en_in = en; ctl_restart_in = rs; ctl_sel_in = sel;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_restart_in = 1'b0;
  endtask

  task automatic give_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_len(string req);
    int w = 0;
    while (wdt_rst && w < 100) begin
      w++;
      @(negedge clk);
    end
    check(req, w, PLEN);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R3 en after por", ctl_en, 0);
    check("R3 sel after por", ctl_sel, 0);
    check("R3 restart after por", ctl_restart, 0);
    check("R3 rst after por", wdt_rst, 0);
    give_ticks(3 * BASE);
    check("R3 disabled ignores ticks", wdt_rst, 0);
  endtask

  task automatic t_periods();
    for (int s = 0; s < 8; s++) begin
      int lim = BASE << s;
      wr_ctl(1'b1, 1'b1, 3'(s));
      check("R10 sel readback", ctl_sel, s);
      check("R10 en readback", ctl_en, 1);
      give_ticks(lim - 1);
      check(s == 7 ? "R2 no fire at limit-1" : "R1 no fire at limit-1", wdt_rst, 0);
      give_ticks(1);
      check(s == 7 ? "R2 fire at limit" : "R1 fire at limit", wdt_rst, 1);
      pulse_len("R8 pulse width");
      give_ticks(lim - 1);
      check("R8 count restarts at zero", wdt_rst, 0);
      give_ticks(1);
      check("R8 second timeout", wdt_rst, 1);
      pulse_len("R8 pulse width again");
    end
  endtask

  task automatic t_restart();
    wr_ctl(1'b1, 1'b1, 3'd0);
    give_ticks(BASE - 2);
    wr_ctl(1'b1, 1'b1, 3'd0);
    check("R7 restart reads 1", ctl_restart, 1);
    @(negedge clk);
    check("R7 restart self clears", ctl_restart, 0);
    give_ticks(BASE - 1);
    check("R5 restart cleared count", wdt_rst, 0);
    give_ticks(1);
    check("R5 fire after restart", wdt_rst, 1);
    pulse_len("R8 width after restart");
    // restart together with a tick: restart wins
    give_ticks(BASE - 2);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en_in = 1'b1; ctl_restart_in = 1'b1; ctl_sel_in = 3'd0;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_restart_in = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    give_ticks(BASE - 1);
    check("R5 restart beats tick", wdt_rst, 0);
    give_ticks(1);
    check("R5 fire after tie", wdt_rst, 1);
    pulse_len("R8 width after tie");
  endtask

  task automatic t_disable();
    wr_ctl(1'b1, 1'b1, 3'd0);
    give_ticks(10);
    wr_ctl(1'b0, 1'b0, 3'd0);
    give_ticks(2 * BASE);
    check("R3 disabled no fire", wdt_rst, 0);
    wr_ctl(1'b1, 1'b0, 3'd0);
    give_ticks(BASE - 1);
    check("R3 disable cleared count", wdt_rst, 0);
    give_ticks(1);
    check("R3 fire after re-enable", wdt_rst, 1);
    pulse_len("R8 width after re-enable");
  endtask

  task automatic t_pdown();
    wr_ctl(1'b1, 1'b1, 3'd0);
    give_ticks(10);
    pdown = 1'b1;
    give_ticks(3 * BASE);
    check("R4 pdown no fire", wdt_rst, 0);
    check("R4 pdown keeps enable", ctl_en, 1);
    pdown = 1'b0;
    give_ticks(BASE - 1);
    check("R4 pdown cleared count", wdt_rst, 0);
    give_ticks(1);
    check("R4 fire after pdown", wdt_rst, 1);
    pulse_len("R8 width after pdown");
  endtask

  task automatic t_por_mid();
    wr_ctl(1'b1, 1'b1, 3'd3);
    give_ticks(10);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    check("R3 por clears en", ctl_en, 0);
    check("R3 por clears sel", ctl_sel, 0);
    por_n = 1'b1;
    give_ticks(3 * BASE);
    check("R3 disabled after por", wdt_rst, 0);
  endtask

  task automatic t_sel_change();
    wr_ctl(1'b1, 1'b1, 3'd2);
    give_ticks(20);
    wr_ctl(1'b1, 1'b0, 3'd0);
    check("R9 no fire on shrink write", wdt_rst, 0);
    give_ticks(1);
    check("R9 shrink fires next tick", wdt_rst, 1);
    pulse_len("R8 width after shrink");
    wr_ctl(1'b1, 1'b1, 3'd0);
    give_ticks(10);
    wr_ctl(1'b1, 1'b0, 3'd1);
    give_ticks(2 * BASE - 11);
    check("R9 grow keeps count", wdt_rst, 0);
    give_ticks(1);
    check("R9 grow fires at new limit", wdt_rst, 1);
    pulse_len("R8 width after grow");
  endtask

  task automatic t_no_ticks();
    int seen = 0;
    wr_ctl(1'b1, 1'b1, 3'd0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    check("R6 clocks alone never fire", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset_state();
    t_periods();
    t_restart();
    t_disable();
    t_pdown();
    t_por_mid();
    t_sel_change();
    t_no_ticks();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule